// File: doc/BRIEF.md
# Trapping Stack-Machine ALU

This block is the arithmetic and logic unit of a 32-bit stack processor. A start strobe presents two operand words, an operation code and a trap-condition select. One clock later the block returns the result word, a two-bit trap code and a valid pulse. Operand selection, stack-pointer handling and trap dispatch are done elsewhere.

The block holds one piece of state: a carry flag that links multi-word arithmetic. Signed operations consume the carry and then clear it. Unsigned operations consume it and then set it from the carry-out or borrow. Lisp-style operations and plain operations ignore it. A separate trap-condition select decides which faults the issuing instruction wants reported: none, signed overflow, a bounds violation, or a tagged-integer fault. While a trap is reported the carry flag is left as it was, so the trap handler sees the carry state from before the instruction.

Operation codes on `op_sel`: 0 OR, 1 AND, 2 XOR, 3 bounds check, 4 signed add, 5 signed subtract, 6 Lisp add, 7 Lisp subtract, 8 unsigned add, 9 unsigned subtract, 10 plain add, 11 plain subtract, 12 to 15 unused. Trap-condition codes on `cond_sel`: 0 none, 1 overflow, 2 bounds, 3 Lisp. Trap codes on `trap`: 0 none, 1 overflow, 2 bounds violation, 3 Lisp NaN.

Top module: `trap_alu`

## Requirements
- R1: When `start` is high at a rising clock edge, `result` and `trap` take that operation's values at that same edge and `valid` is high for the following cycle only. Without `start`, `result` and `trap` hold their values and `valid` is low.
- R2: While `rst_n` is low, `result`, `trap`, `carry` and `valid` are all 0.
- R3: Op codes 0, 1 and 2 return A OR B, A AND B and A XOR B. They never trap and leave the carry unchanged.
- R4: Op code 4 returns A+B+carry and op code 5 returns A-B-carry. Each clears the carry. With condition code 1, signed overflow gives trap code 1.
- R5: Op code 3 returns A unchanged. With condition code 2 it gives trap code 2 when A is negative or when A is greater than or equal to B as signed numbers. The carry is unchanged.
- R6: Op codes 6 and 7 return A+B and A-B and ignore the incoming carry. With condition code 3 they give trap code 3 if A, B or the result has bits 31 and 30 unequal. Otherwise they give trap code 1 on signed overflow. When no trap is given, they clear the carry.
- R7: Op code 8 returns A+B+carry and sets the carry to the carry-out. Op code 9 returns A-B-carry and sets the carry to the borrow. Neither ever traps, whatever the condition code.
- R8: Op codes 10 and 11 return A+B and A-B. They never trap and never read or change the carry.
- R9: Condition code 0 suppresses every trap, and a condition code only reports the fault class it names. A signed overflow under condition code 0 still clears the carry.
- R10: When the trap code produced is non-zero, the carry flag keeps its previous value. The result word is still delivered.
- R11: Op codes 12 to 15 return 0, never trap and leave the carry unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | Operation strobe, one per operation |
| op_a | input | 32 | Operand A |
| op_b | input | 32 | Operand B |
| op_sel | input | 4 | Operation code |
| cond_sel | input | 2 | Trap-condition select |
| result | output | 32 | Registered result word |
| trap | output | 2 | Registered trap code |
| carry | output | 1 | Current carry flag |
| valid | output | 1 | High the cycle after a start |

## Verification
A wrong carry bit is not visible in `result` right away. It shows up in the next signed or unsigned add or subtract, as a result that is off by one or as a wrong carry value, one cycle after that operation's start. For that reason the vectors chain carry-producing operations into carry-consuming ones. A carry changed while a trap is reported shows on the `carry` port in the same cycle as the trap. The vectors include trapping operations that follow a carry set to 1.

// File: rtl/trap_alu_pkg.sv
package trap_alu_pkg;
  typedef enum logic [3:0] {
    OP_OR   = 4'd0,
    OP_AND  = 4'd1,
    OP_XOR  = 4'd2,
    OP_BND  = 4'd3,
    OP_SADD = 4'd4,
    OP_SSUB = 4'd5,
    OP_LADD = 4'd6,
    OP_LSUB = 4'd7,
    OP_UADD = 4'd8,
    OP_USUB = 4'd9,
    OP_VADD = 4'd10,
    OP_VSUB = 4'd11
  } alu_op_e;

  typedef enum logic [1:0] {
    CND_NONE = 2'd0,
    CND_OVF  = 2'd1,
    CND_BND  = 2'd2,
    CND_LISP = 2'd3
  } trap_cond_e;

  typedef enum logic [1:0] {
    TRP_NONE = 2'd0,
    TRP_OVF  = 2'd1,
    TRP_BND  = 2'd2,
    TRP_NAN  = 2'd3
  } trap_code_e;
endpackage

// File: rtl/trap_alu_addsub.sv
module trap_alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic         cin_use,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);
  logic [W-1:0] b_eff;
  logic         c0;
  logic [W:0]   wide;

  always_comb begin
    b_eff = sub ? ~b : b;
    // subtract: A + ~B + (1 - borrow_in)
    c0    = sub ? ~(cin_use & cin) : (cin_use & cin);
    wide  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, c0};
    sum   = wide[W-1:0];
    cout  = wide[W];
    ovf   = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
  end
endmodule

// File: rtl/trap_alu_judge.sv
module trap_alu_judge
  import trap_alu_pkg::*;
(
  input  logic [1:0] cond_sel,
  input  logic       ovf_flag,
  input  logic       bnd_flag,
  input  logic       nan_flag,
  output logic [1:0] trap_code
);
  always_comb begin
    trap_code = TRP_NONE;
    unique case (trap_cond_e'(cond_sel))
      CND_NONE: trap_code = TRP_NONE;
      CND_OVF:  if (ovf_flag) trap_code = TRP_OVF;
      CND_BND:  if (bnd_flag) trap_code = TRP_BND;
      CND_LISP: begin
        if (nan_flag)      trap_code = TRP_NAN;
        else if (ovf_flag) trap_code = TRP_OVF;
      end
      default:  trap_code = TRP_NONE;
    endcase
  end
endmodule

// File: rtl/trap_alu.sv
module trap_alu
  import trap_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [3:0]   op_sel,
  input  logic [1:0]   cond_sel,
  output logic [W-1:0] result,
  output logic [1:0]   trap,
  output logic         carry,
  output logic         valid
);
  localparam int TOP = W - 1;
  localparam int TAG = W - 2;

  logic         as_sub, as_cin_use;
  logic [W-1:0] as_sum;
  logic         as_cout, as_ovf;
  logic         is_signed, is_lisp, is_uns, is_bnd;
  logic         ovf_flag, bnd_flag, nan_flag;
  logic [1:0]   trap_nxt;
  logic [W-1:0] res_nxt;
  logic         carry_nxt;

  always_comb begin
    is_signed  = (op_sel == OP_SADD) || (op_sel == OP_SSUB);
    is_lisp    = (op_sel == OP_LADD) || (op_sel == OP_LSUB);
    is_uns     = (op_sel == OP_UADD) || (op_sel == OP_USUB);
    is_bnd     = (op_sel == OP_BND);
    as_sub     = (op_sel == OP_SSUB) || (op_sel == OP_LSUB) ||
                 (op_sel == OP_USUB) || (op_sel == OP_VSUB);
    as_cin_use = is_signed || is_uns;
  end

  trap_alu_addsub #(.W(W)) u_as (
    .a       (op_a),
    .b       (op_b),
    .sub     (as_sub),
    .cin_use (as_cin_use),
    .cin     (carry),
    .sum     (as_sum),
    .cout    (as_cout),
    .ovf     (as_ovf)
  );

  always_comb begin
    ovf_flag = (is_signed || is_lisp) && as_ovf;
    bnd_flag = is_bnd && (op_a[TOP] || !($signed(op_a) < $signed(op_b)));
    nan_flag = is_lisp && ((op_a[TOP] ^ op_a[TAG]) ||
                           (op_b[TOP] ^ op_b[TAG]) ||
                           (as_sum[TOP] ^ as_sum[TAG]));
  end

  trap_alu_judge u_judge (
    .cond_sel  (cond_sel),
    .ovf_flag  (ovf_flag),
    .bnd_flag  (bnd_flag),
    .nan_flag  (nan_flag),
    .trap_code (trap_nxt)
  );

  always_comb begin
    res_nxt = '0;
    case (op_sel)
      OP_OR:   res_nxt = op_a | op_b;
      OP_AND:  res_nxt = op_a & op_b;
      OP_XOR:  res_nxt = op_a ^ op_b;
      OP_BND:  res_nxt = op_a;
      OP_SADD, OP_SSUB, OP_LADD, OP_LSUB,
      OP_UADD, OP_USUB, OP_VADD, OP_VSUB: res_nxt = as_sum;
      default: res_nxt = '0;
    endcase

    carry_nxt = carry;
    if (trap_nxt == TRP_NONE) begin
      if (is_signed || is_lisp)    carry_nxt = 1'b0;
      else if (op_sel == OP_UADD)  carry_nxt = as_cout;
      else if (op_sel == OP_USUB)  carry_nxt = ~as_cout;
    end
  end

  // datapath registers, enabled by start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
      trap   <= 2'd0;
      carry  <= 1'b0;
    end else if (start) begin
      result <= res_nxt;
      trap   <= trap_nxt;
      carry  <= carry_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid <= 1'b0;
    else        valid <= start;
  end
endmodule

// File: rtl/trap_alu_chk.sv
module trap_alu_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [W-1:0] op_a,
  input logic [3:0]   op_sel,
  input logic [1:0]   cond_sel,
  input logic [W-1:0] result,
  input logic [1:0]   trap,
  input logic         carry,
  input logic         valid
);
  // R1
  valid_follows_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> valid);
  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (!valid && $stable(result) && $stable(trap)));
  // R3
  logic_no_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op_sel <= 4'd2) |=> (trap == 2'd0));
  // R5
  bound_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op_sel == 4'd3) |=> (result == $past(op_a)));
  // R4
  signed_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (op_sel == 4'd4 || op_sel == 4'd5)) |=> (trap != 2'd0 || !carry));
  // R9
  cond_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && cond_sel == 2'd0) |=> (trap == 2'd0));
  // R10
  trap_keeps_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && trap != 2'd0) |-> (carry == $past(carry)));
  // R8
  plain_keeps_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (op_sel == 4'd10 || op_sel == 4'd11)) |=> $stable(carry));
endmodule

bind trap_alu trap_alu_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .op_a     (op_a),
  .op_sel   (op_sel),
  .cond_sel (cond_sel),
  .result   (result),
  .trap     (trap),
  .carry    (carry),
  .valid    (valid)
);

// File: tb/sim_trap_alu.sv
module sim_trap_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic [3:0]  op_sel = '0;
  logic [1:0]  cond_sel = '0;
  logic [31:0] result;
  logic [1:0]  trap;
  logic        carry, valid;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  trap_alu u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
    .op_sel(op_sel), .cond_sel(cond_sel), .result(result), .trap(trap),
    .carry(carry), .valid(valid)
  );

  // {op, cond, a, b, expected result, expected trap, expected carry afterwards}
  localparam int NV = 26;
  localparam logic [104:0] VEC [NV] = '{
    {4'd0, 2'd0, 32'hF0F0_0000, 32'h0000_0F0F, 32'hF0F0_0F0F, 2'd0, 1'b0}, // R3 OR
    {4'd8, 2'd0, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000, 2'd0, 1'b1}, // R7 carry-out
    {4'd4, 2'd1, 32'h0000_0005, 32'h0000_0003, 32'h0000_0009, 2'd0, 1'b0}, // R4 uses carry, clears
    {4'd8, 2'd1, 32'h8000_0000, 32'h8000_0000, 32'h0000_0000, 2'd0, 1'b1}, // R7 no trap under ovf
    {4'd10,2'd0, 32'h0000_0001, 32'h0000_0002, 32'h0000_0003, 2'd0, 1'b1}, // R8 keeps carry
    {4'd9, 2'd0, 32'h0000_0005, 32'h0000_0003, 32'h0000_0001, 2'd0, 1'b0}, // R7 sub with borrow-in
    {4'd9, 2'd0, 32'h0000_0003, 32'h0000_0005, 32'hFFFF_FFFE, 2'd0, 1'b1}, // R7 borrow out
    {4'd4, 2'd1, 32'h7FFF_FFFF, 32'h0000_0000, 32'h8000_0000, 2'd1, 1'b1}, // R4 R10 overflow keeps carry
    {4'd5, 2'd1, 32'h0000_000A, 32'h0000_0004, 32'h0000_0005, 2'd0, 1'b0}, // R4 sub with carry
    {4'd5, 2'd1, 32'h8000_0000, 32'h0000_0001, 32'h7FFF_FFFF, 2'd1, 1'b0}, // R4 sub overflow
    {4'd3, 2'd2, 32'h0000_0005, 32'h0000_000A, 32'h0000_0005, 2'd0, 1'b0}, // R5 in range
    {4'd3, 2'd2, 32'h0000_000A, 32'h0000_000A, 32'h0000_000A, 2'd2, 1'b0}, // R5 A equal to B
    {4'd3, 2'd2, 32'hFFFF_FFFF, 32'h0000_000A, 32'hFFFF_FFFF, 2'd2, 1'b0}, // R5 negative
    {4'd8, 2'd0, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000, 2'd0, 1'b1}, // R7 set carry
    {4'd6, 2'd3, 32'h0000_0003, 32'h0000_0004, 32'h0000_0007, 2'd0, 1'b0}, // R6 ignores carry, clears
    {4'd6, 2'd3, 32'h4000_0000, 32'h0000_0001, 32'h4000_0001, 2'd3, 1'b0}, // R6 NaN operand
    {4'd6, 2'd3, 32'h3FFF_FFFF, 32'h0000_0001, 32'h4000_0000, 2'd3, 1'b0}, // R6 NaN result
    {4'd7, 2'd3, 32'h0000_0005, 32'hC000_0000, 32'h4000_0005, 2'd3, 1'b0}, // R6 sub NaN result
    {4'd2, 2'd0, 32'h1234_5678, 32'hFFFF_0000, 32'hEDCB_5678, 2'd0, 1'b0}, // R3 XOR
    {4'd1, 2'd0, 32'h1234_5678, 32'h0F0F_0F0F, 32'h0204_0608, 2'd0, 1'b0}, // R3 AND
    {4'd11,2'd0, 32'h0000_0000, 32'h0000_0001, 32'hFFFF_FFFF, 2'd0, 1'b0}, // R8 sub
    {4'd4, 2'd0, 32'h7FFF_FFFF, 32'h0000_0001, 32'h8000_0000, 2'd0, 1'b0}, // R9 cond off
    {4'd6, 2'd3, 32'h8000_0000, 32'h8000_0000, 32'h0000_0000, 2'd3, 1'b0}, // R6 NaN over overflow
    {4'd8, 2'd1, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000, 2'd0, 1'b1}, // R7 cond ovf ignored
    {4'd10,2'd1, 32'h7FFF_FFFF, 32'h0000_0001, 32'h8000_0000, 2'd0, 1'b1}, // R8 never traps
    {4'd15,2'd0, 32'h0000_0001, 32'h0000_0001, 32'h0000_0000, 2'd0, 1'b1}  // R11 unused code
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] o, input logic [1:0] c,
                       input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    op_sel = o; cond_sel = c; op_a = a; op_b = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin : watchdog
    #200000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R2 reset state
    chk("R2 result", result, 32'h0);
    chk("R2 trap", {30'h0, trap}, 32'h0);
    chk("R2 carry", {31'h0, carry}, 32'h0);
    chk("R2 valid", {31'h0, valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][104:101], VEC[i][100:99], VEC[i][98:67], VEC[i][66:35]);
      chk($sformatf("R1 valid v%0d", i), {31'h0, valid}, 32'h1);
      chk($sformatf("result v%0d", i), result, VEC[i][34:3]);
      chk($sformatf("trap v%0d", i), {30'h0, trap}, {30'h0, VEC[i][2:1]});
      chk($sformatf("carry v%0d", i), {31'h0, carry}, {31'h0, VEC[i][0]});
    end

    // R1 hold while idle, inputs changing
    op_a = 32'hDEAD_BEEF; op_b = 32'h1; op_sel = 4'd0; cond_sel = 2'd3;
    repeat (3) @(negedge clk);
    chk("R1 hold valid", {31'h0, valid}, 32'h0);
    chk("R1 hold result", result, 32'h0);
    chk("R1 hold trap", {30'h0, trap}, 32'h0);
    chk("R11 carry kept", {31'h0, carry}, 32'h1);

    // R10 trap after carry=1: bounds violation keeps carry 1
    issue(4'd3, 2'd2, 32'h0000_0020, 32'h0000_0010);
    chk("R10 trap", {30'h0, trap}, 32'h2);
    chk("R10 carry", {31'h0, carry}, 32'h1);

    // R2 reset mid-run clears state
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R2 carry cleared", {31'h0, carry}, 32'h0);
    chk("R2 result cleared", result, 32'h0);
    chk("R2 trap cleared", {30'h0, trap}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule